// File: doc/BRIEF.md
# Serial Command Register Slave

This block is a write-only serial slave for the configuration registers of a clock synthesizer. A host moves 32-bit command frames over three lines: an active-low chip select, a serial clock and a serial data line. The block samples these lines in its own system clock domain, so the serial clock must run well below the system clock. It puts the bits together into a frame. When chip select is deasserted after exactly 32 bits, it decodes the frame.

A frame starts with a 2-bit address and continues with 30 data bits. Address `{A1,A0}` = 00 loads the divider register. That register holds an output-divide code, a feedback divide ratio and a reference divide ratio. Address 10 loads the control word, which holds the pulse, trigger, halt, loop and output-select bits. Address 11 writes no register. It issues a dummy-trigger strobe that lasts one system clock. Address 01 is reserved and has no effect. A partial frame is dropped, and so is an overlong one. An asynchronous reset clears every register.

Top module: `sercmd_if`

## Requirements
- R1: While `rst_n` is low and after it rises, every configuration output is 0 and `dummy_trig` is 0. Reset takes effect asynchronously.
- R2: A bit is taken on each rising edge of `sclk` while `cs_n` is low. The first bit is A0, the second is A1, and D0 through D29 follow. The address is `{A1,A0}`.
- R3: A frame with address 00 sets `odiv_code` = D[2:0], `fb_div` = D[17:3] and `ref_div` = D[29:18]. The control outputs are left unchanged.
- R4: A frame with address 10 sets the control outputs from the data bits: `out_sel`=D0, `halt_all`=D1, `vco_halt`=D2, `cp_halt`=D3, `lpf_open`=D4, `pd_out_en`=D5, `trig_edge`=D6, `pulse_pol`=D7 and `pulse_width`=D[9:8]. Data bits D10 to D29 are ignored, and the divider outputs are left unchanged.
- R5: A frame with address 11 raises `dummy_trig` for exactly one system clock cycle. No configuration output changes.
- R6: A frame with address 01 changes no output and raises no strobe.
- R7: A frame closed after fewer than 32 bits is discarded.
- R8: A frame closed after more than 32 bits is discarded.
- R9: Outputs change only after `cs_n` rises. While a complete 32-bit frame is still open, the outputs keep their old values.
- R10: A rising edge of `sclk` that arrives together with the rising edge of `cs_n` still counts as a frame bit. If that edge is the 32nd bit, the frame is accepted.
- R11: Edges on `sclk` while `cs_n` is high are ignored. The next frame is then decoded correctly.
- R12: A reset asserted in the middle of a frame drops the partial frame. Closing that frame afterwards changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from host |
| sclk | input | 1 | Serial bit clock from host |
| sdi | input | 1 | Serial data from host |
| odiv_code | output | 3 | Output-divide code |
| fb_div | output | 15 | Feedback divide ratio |
| ref_div | output | 12 | Reference divide ratio |
| out_sel | output | 1 | Output multiplexer select |
| halt_all | output | 1 | Global halt |
| vco_halt | output | 1 | Oscillator halt |
| cp_halt | output | 1 | Charge-pump halt |
| lpf_open | output | 1 | Loop filter disconnect |
| pd_out_en | output | 1 | Phase-detector output enable |
| trig_edge | output | 1 | Trigger edge select |
| pulse_pol | output | 1 | One-shot polarity |
| pulse_width | output | 2 | One-shot width code |
| dummy_trig | output | 1 | One-cycle dummy-trigger strobe |

## Verification
The 32nd bit and the end of the frame can arrive in the same system clock cycle. This happens when the host raises `sclk` and `cs_n` at the same instant, so both rising edges clear the synchronizer together. The bench provokes this case by driving the two lines in one time step. It passes only if the frame is taken as complete and its divider fields appear on the outputs. The 31-bit and 33-bit frames around it must still be rejected.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

   typedef enum logic [1:0] {
      ADR_DIV   = 2'b00,
      ADR_RSVD  = 2'b01,
      ADR_CTRL  = 2'b10,
      ADR_DUMMY = 2'b11
   } cmd_addr_e;

   // Field order from MSB down to LSB. out_sel is carried by data bit 0.
   typedef struct packed {
      logic [1:0] pulse_width;
      logic       pulse_pol;
      logic       trig_edge;
      logic       pd_out_en;
      logic       lpf_open;
      logic       cp_halt;
      logic       vco_halt;
      logic       halt_all;
      logic       out_sel;
   } ctrl_word_t;

   localparam int CTRL_W = $bits(ctrl_word_t);
   localparam int ADDR_W = 2;

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sercmd_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sercmd_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/sercmd_shift.sv
module sercmd_shift #(
   parameter int FRAME_W = 32,
   localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_s,
   input  logic               sclk_s,
   input  logic               sdi_s,
   output logic               frame_vld,
   output logic [FRAME_W-1:0] frame_word,
   output logic [CNT_W-1:0]   bit_cnt
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

   if (FRAME_W < 4) begin : g_bad_frame
      $error("sercmd_shift: FRAME_W too small");
   end

   logic               sclk_d, cs_d;
   logic [FRAME_W-1:0] sh_q, sh_nx;
   logic [CNT_W-1:0]   cnt_q, cnt_nx;
   logic               take, cs_rise;

   // A bit is taken when the clock rises and select was low one sample earlier.
   // This lets an sclk edge that arrives together with the select edge still count.
   always_comb begin
      take    = sclk_s & ~sclk_d & ~cs_d;
      cs_rise = cs_s & ~cs_d;
      sh_nx   = take ? {sdi_s, sh_q[FRAME_W-1:1]} : sh_q;
      cnt_nx  = (take && cnt_q != CNT_SAT) ? cnt_q + 1'b1 : cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d     <= 1'b0;
         cs_d       <= 1'b1;
         sh_q       <= '0;
         cnt_q      <= '0;
         frame_vld  <= 1'b0;
         frame_word <= '0;
      end else begin
         sclk_d    <= sclk_s;
         cs_d      <= cs_s;
         sh_q      <= sh_nx;
         cnt_q     <= cs_d ? '0 : cnt_nx;
         frame_vld <= cs_rise && (cnt_nx == CNT_FULL);
         if (cs_rise && (cnt_nx == CNT_FULL)) frame_word <= sh_nx;
      end
   end

   assign bit_cnt = cnt_q;

endmodule

// File: rtl/sercmd_regs.sv
module sercmd_regs
   import sercmd_pkg::*;
#(
   parameter int ODIV_W = 3,
   parameter int FB_W   = 15,
   parameter int REF_W  = 12,
   localparam int DATA_W  = ODIV_W + FB_W + REF_W,
   localparam int FRAME_W = ADDR_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_vld,
   input  logic [FRAME_W-1:0] frame_word,
   output logic [ODIV_W-1:0]  odiv_q,
   output logic [FB_W-1:0]    fb_q,
   output logic [REF_W-1:0]   ref_q,
   output ctrl_word_t         ctrl_q,
   output logic               dummy_q
);

   localparam int FB_LSB  = ODIV_W;
   localparam int REF_LSB = ODIV_W + FB_W;

   if (CTRL_W > DATA_W) begin : g_bad_ctrl
      $error("sercmd_regs: control word wider than data field");
   end

   cmd_addr_e         addr;
   logic [DATA_W-1:0] data;

   assign addr = cmd_addr_e'(frame_word[ADDR_W-1:0]);
   assign data = frame_word[FRAME_W-1:ADDR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odiv_q  <= '0;
         fb_q    <= '0;
         ref_q   <= '0;
         ctrl_q  <= '0;
         dummy_q <= 1'b0;
      end else begin
         dummy_q <= 1'b0;
         if (frame_vld) begin
            unique case (addr)
               ADR_DIV: begin
                  odiv_q <= data[ODIV_W-1:0];
                  fb_q   <= data[FB_LSB +: FB_W];
                  ref_q  <= data[REF_LSB +: REF_W];
               end
               ADR_CTRL:  ctrl_q  <= ctrl_word_t'(data[CTRL_W-1:0]);
               ADR_DUMMY: dummy_q <= 1'b1;
               default:   ;
            endcase
         end
      end
   end

endmodule

// File: rtl/sercmd_if.sv
module sercmd_if
   import sercmd_pkg::*;
#(
   parameter int ODIV_W      = 3,
   parameter int FB_W        = 15,
   parameter int REF_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic [ODIV_W-1:0] odiv_code,
   output logic [FB_W-1:0]   fb_div,
   output logic [REF_W-1:0]  ref_div,
   output logic              out_sel,
   output logic              halt_all,
   output logic              vco_halt,
   output logic              cp_halt,
   output logic              lpf_open,
   output logic              pd_out_en,
   output logic              trig_edge,
   output logic              pulse_pol,
   output logic [1:0]        pulse_width,
   output logic              dummy_trig
);

   localparam int DATA_W  = ODIV_W + FB_W + REF_W;
   localparam int FRAME_W = ADDR_W + DATA_W;
   localparam int CNT_W   = $clog2(FRAME_W + 2);
   localparam int CFG_W   = ODIV_W + FB_W + REF_W + CTRL_W;

   logic [2:0]         pins_s;
   logic               frame_vld;
   logic [FRAME_W-1:0] frame_word;
   logic [1:0]         frame_addr;
   logic [CNT_W-1:0]   bit_cnt;
   ctrl_word_t         ctrl;
   logic [CFG_W-1:0]   cfg_all;

   sercmd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     (pins_s)
   );

   sercmd_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_s       (pins_s[2]),
      .sclk_s     (pins_s[1]),
      .sdi_s      (pins_s[0]),
      .frame_vld  (frame_vld),
      .frame_word (frame_word),
      .bit_cnt    (bit_cnt)
   );

   sercmd_regs #(.ODIV_W(ODIV_W), .FB_W(FB_W), .REF_W(REF_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_vld  (frame_vld),
      .frame_word (frame_word),
      .odiv_q     (odiv_code),
      .fb_q       (fb_div),
      .ref_q      (ref_div),
      .ctrl_q     (ctrl),
      .dummy_q    (dummy_trig)
   );

   assign frame_addr  = frame_word[1:0];
   assign out_sel     = ctrl.out_sel;
   assign halt_all    = ctrl.halt_all;
   assign vco_halt    = ctrl.vco_halt;
   assign cp_halt     = ctrl.cp_halt;
   assign lpf_open    = ctrl.lpf_open;
   assign pd_out_en   = ctrl.pd_out_en;
   assign trig_edge   = ctrl.trig_edge;
   assign pulse_pol   = ctrl.pulse_pol;
   assign pulse_width = ctrl.pulse_width;
   assign cfg_all     = {odiv_code, fb_div, ref_div, ctrl};

endmodule

// File: rtl/sercmd_if_chk.sv
module sercmd_if_chk #(
   parameter int CFG_W   = 40,
   parameter int CNT_W   = 6,
   parameter int FRAME_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_vld,
   input logic [1:0]       frame_addr,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [CFG_W-1:0] cfg_all,
   input logic             dummy_trig
);

   // R9: configuration moves only in the cycle after an accepted frame
   a_r9_hold_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld |=> $stable(cfg_all));

   // R6: reserved address leaves everything alone
   a_r6_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && frame_addr == 2'b01) |=> ($stable(cfg_all) && !dummy_trig));

   // R5: strobe lasts one cycle
   a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      dummy_trig |=> !dummy_trig);

   // R5: strobe only follows an accepted dummy frame
   a_r5_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
      dummy_trig |-> ($past(frame_vld) && $past(frame_addr) == 2'b11));

   // R5: dummy frame loads nothing
   a_r5_dummy_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && frame_addr == 2'b11) |=> $stable(cfg_all));

   // R2: frame acceptance is a single-cycle pulse
   a_r2_accept_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld |=> !frame_vld);

   // R8: bit counter saturates just past a full frame
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W + 1));

endmodule

bind sercmd_if sercmd_if_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_vld  (frame_vld),
   .frame_addr (frame_addr),
   .bit_cnt    (bit_cnt),
   .cfg_all    (cfg_all),
   .dummy_trig (dummy_trig)
);

// File: tb/sercmd_if_test.sv
module sercmd_if_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic [2:0]  odiv_code;
   logic [14:0] fb_div;
   logic [11:0] ref_div;
   logic out_sel, halt_all, vco_halt, cp_halt, lpf_open, pd_out_en, trig_edge, pulse_pol;
   logic [1:0] pulse_width;
   logic dummy_trig;

   int checks = 0;
   int fails = 0;
   int strobe_cycles = 0;
   int exp_strobes = 0;
   bit done = 1'b0;

   logic [2:0]  e_odiv = '0;
   logic [14:0] e_fb = '0;
   logic [11:0] e_ref = '0;
   logic [9:0]  e_ctrl = '0;

   always #10 clk = ~clk;

   sercmd_if uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .odiv_code(odiv_code), .fb_div(fb_div), .ref_div(ref_div),
      .out_sel(out_sel), .halt_all(halt_all), .vco_halt(vco_halt), .cp_halt(cp_halt),
      .lpf_open(lpf_open), .pd_out_en(pd_out_en), .trig_edge(trig_edge),
      .pulse_pol(pulse_pol), .pulse_width(pulse_width), .dummy_trig(dummy_trig)
   );

   always @(posedge clk) if (dummy_trig) strobe_cycles++;

   // {addr[1:0], data[29:0]}
   localparam logic [31:0] VEC [8] = '{
      {2'b00, 30'h1234_5678},
      {2'b10, 30'h0000_03FF},
      {2'b11, 30'h3FFF_FFFF},
      {2'b01, 30'h0ABC_DEF1},
      {2'b00, 30'h3FFF_FFFF},
      {2'b10, 30'h0000_0155},
      {2'b00, 30'h0000_0001},
      {2'b10, 30'h3C00_02AA}
   };

   function automatic logic [39:0] observed();
      return {odiv_code, fb_div, ref_div, pulse_width, pulse_pol, trig_edge,
              pd_out_en, lpf_open, cp_halt, vco_halt, halt_all, out_sel};
   endfunction

   function automatic logic [39:0] expected();
      return {e_odiv, e_fb, e_ref, e_ctrl};
   endfunction

   task automatic model(input logic [1:0] a, input logic [29:0] d);
      case (a)
         2'b00: begin e_odiv = d[2:0]; e_fb = d[17:3]; e_ref = d[29:18]; end
         2'b10: e_ctrl = d[9:0];
         2'b11: exp_strobes++;
         default: ;
      endcase
   endtask

   task automatic check_cfg(input string req);
      checks++;
      if (observed() !== expected()) begin
         fails++;
         $display("FAIL %s: cfg actual=%h expected=%h", req, observed(), expected());
      end
   endtask

   task automatic check_strobe(input string req);
      checks++;
      if (strobe_cycles != exp_strobes) begin
         fails++;
         $display("FAIL %s: strobe cycles actual=%0d expected=%0d", req, strobe_cycles, exp_strobes);
      end
   endtask

   // Sends nbits bits; merge raises cs_n with the last sclk edge; open leaves cs_n low.
   task automatic send(input logic [1:0] a, input logic [29:0] d, input int nbits,
                       input bit merge, input bit open);
      logic [31:0] w;
      w = {d, a[1], a[0]};
      cs_n = 1'b0;
      #100;
      for (int k = 0; k < nbits; k++) begin
         sdi = (k < 32) ? w[k] : 1'b0;
         #100;
         sclk = 1'b1;
         if (merge && k == nbits - 1) cs_n = 1'b1;
         #100;
         sclk = 1'b0;
      end
      #100;
      if (!open) cs_n = 1'b1;
      #400;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #200_000_0;
      #200_000_0;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      finish_run();
   end

   initial begin
      #105;
      check_cfg("R1 during reset");
      rst_n = 1'b1;
      #200;
      check_cfg("R1 after reset");
      check_strobe("R1 no strobe");

      // vector table: R2 bit order, R3 divider, R4 control, R5 dummy, R6 reserved
      for (int i = 0; i < 8; i++) begin
         send(VEC[i][31:30], VEC[i][29:0], 32, 1'b0, 1'b0);
         model(VEC[i][31:30], VEC[i][29:0]);
         check_cfg($sformatf("R2/R3/R4/R6 vector %0d", i));
         check_strobe($sformatf("R5 vector %0d", i));
      end

      // R7: short frame
      send(2'b00, 30'h2222_2222, 31, 1'b0, 1'b0);
      check_cfg("R7 31-bit frame dropped");

      // R8: long frame
      send(2'b00, 30'h1111_1111, 33, 1'b0, 1'b0);
      check_cfg("R8 33-bit frame dropped");

      // R9: complete frame still open
      send(2'b00, 30'h0765_4321, 32, 1'b0, 1'b1);
      check_cfg("R9 no update while cs_n low");
      cs_n = 1'b1;
      #400;
      model(2'b00, 30'h0765_4321);
      check_cfg("R9 update after cs_n rises");

      // R10: last edge coincident with frame close
      send(2'b00, 30'h2ACE_1357, 32, 1'b1, 1'b0);
      model(2'b00, 30'h2ACE_1357);
      check_cfg("R10 coincident last edge accepted");

      // R11: stray clocks while deselected
      for (int k = 0; k < 5; k++) begin
         sdi = 1'b1; #100; sclk = 1'b1; #100; sclk = 1'b0;
      end
      #400;
      check_cfg("R11 stray sclk ignored");
      send(2'b10, 30'h0000_0366, 32, 1'b0, 1'b0);
      model(2'b10, 30'h0000_0366);
      check_cfg("R11 frame after stray sclk");

      // R5: two dummies back to back
      send(2'b11, 30'h0, 32, 1'b0, 1'b0);
      send(2'b11, 30'h1, 32, 1'b0, 1'b0);
      exp_strobes += 2;
      check_strobe("R5 back-to-back strobes");
      check_cfg("R5 dummy leaves registers");

      // R12: reset mid-frame
      send(2'b00, 30'h3FFF_0000, 16, 1'b0, 1'b1);
      rst_n = 1'b0;
      #100;
      e_odiv = '0; e_fb = '0; e_ref = '0; e_ctrl = '0;
      check_cfg("R1 R12 reset mid-frame clears");
      rst_n = 1'b1;
      #100;
      for (int k = 0; k < 16; k++) begin
         sdi = 1'b1; #100; sclk = 1'b1; #100; sclk = 1'b0;
      end
      #100;
      cs_n = 1'b1;
      #400;
      check_cfg("R12 partial frame after reset dropped");
      check_strobe("R12 no strobe");

      finish_run();
   end

endmodule